// File: doc/BRIEF.md
# Prescaled I2C Byte Transfer Engine

This block is the bit-level engine of an I2C master. It takes one command at a time over a valid/ready handshake. A command moves one byte and may do three optional things around it: send a start condition first, choose between writing and reading the byte, and send a stop condition after the acknowledge slot. A start issued while the engine still holds the bus becomes a repeated start, with no stop in between. The engine never drives a line high. It pulls SCL or SDA low through an output-enable, and it reads both lines back through a two-flop synchroniser.

All bus timing comes from a 16-bit prescale value. A tick occurs every prescale+1 system clocks. Each SCL period lasts five ticks: two with SCL low, with SDA changing between them, then three with SCL released. The received bit is sampled at the end of the fourth tick. A slave may hold SCL low to stretch the clock, and the engine waits for SCL to read high before it continues. The engine also watches the bus for start and stop conditions from any master and reports a busy flag. If it releases SDA for a written one but reads the line low, it gives up at once and releases both lines.

Top module: `i2c_byte_engine`

## Requirements
- R1: A command is taken on a clock edge where cmdValid and cmdReady are both high. From that edge, tip is high and cmdReady is low. At the edge where the command finishes, tip falls and done pulses high for exactly one cycle.
- R2: With no stretching, the engine emits one tick per prescale+1 clocks, and each SCL period is 5 ticks. A command lasts 45 ticks for the byte and acknowledge, plus 5 ticks if a start is requested, plus 5 ticks if a stop is requested, counted from the acceptance edge to the edge where tip falls.
- R3: On a write, txByte goes out MSB first. A one releases SDA and a zero pulls it low. SDA is released in the ninth slot, and the level sampled there is returned on rxNack, where 1 means NACK and 0 means ACK.
- R4: On a read (cmdRead=1), eight bits are sampled MSB first into rxByte. In the ninth slot the engine pulls SDA low when cmdNack=0 (ACK) and releases it when cmdNack=1 (NACK, used for the last byte).
- R5: A start makes SDA fall while SCL is high. If the engine still holds SCL low from an earlier command without a stop, the start becomes a repeated start, and no stop condition appears on the bus.
- R6: A stop makes SDA rise while SCL is high. After a command with stop, both output-enables are low.
- R7: If a written one is sampled low on SDA, arbLost goes to 1 and both output-enables go low in the same edge. The command then ends with done after 4 ticks of that bit. arbLost clears when the next command is accepted.
- R8: busBusy goes to 1 when any start condition is seen on the synchronised lines and to 0 when a stop condition is seen, whichever master produced it.
- R9: In the SCL-high phase of each bit, the engine waits for a tick on which SCL reads high. A stretch therefore lengthens the command by whole ticks.
- R10: While idle, sclOe and sdaOe do not change. After a command without stop, SCL stays pulled low.
- R11: After reset, sclOe, sdaOe, tip, done and busBusy are 0 and cmdReady is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| prescale | input | 16 | Tick divider; tick period is prescale+1 clocks |
| cmdValid | input | 1 | Command request |
| cmdReady | output | 1 | Engine idle, command can be taken |
| cmdStart | input | 1 | Send a start (or repeated start) first |
| cmdStop | input | 1 | Send a stop after the acknowledge slot |
| cmdRead | input | 1 | 1 reads a byte, 0 writes txByte |
| cmdNack | input | 1 | Read only: 1 sends NACK, 0 sends ACK |
| txByte | input | 8 | Byte to write |
| sclIn | input | 1 | SCL line level |
| sdaIn | input | 1 | SDA line level |
| sclOe | output | 1 | 1 pulls SCL low |
| sdaOe | output | 1 | 1 pulls SDA low |
| rxByte | output | 8 | Byte seen on SDA during the last command |
| rxNack | output | 1 | Level seen in the acknowledge slot, 1 = NACK |
| arbLost | output | 1 | Arbitration lost in the last command |
| busBusy | output | 1 | Bus owned between a start and a stop |
| tip | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Every command result becomes due at the done pulse. That pulse comes a fixed number of ticks after the acceptance edge: 45, plus 5 for a start, plus 5 for a stop, 19 for the aborted arbitration case, and two extra ticks for the stretched bit. Each tick is prescale+1 clocks long. The driver puts that cycle count into the scoreboard queue together with the expected byte, acknowledge and arbitration flags. The monitor counts falling clock edges while tip is high and compares everything on the falling edge where done is seen, so each value is read half a cycle after the edge that settled it. Bus-side results need settling time after done: the bits the slave received, the ACK the master drove, the busy flag and the line releases. They are therefore checked on later falling edges, after the two synchroniser stages and the detector register have settled.

// File: rtl/i2c_eng_pkg.sv
package i2c_eng_pkg;

  localparam int PHASE_W = 3;

  // phase indices within one bit slot; the sequence is behaviour
  localparam logic [PHASE_W-1:0] PH_DRIVE   = 3'd0;
  localparam logic [PHASE_W-1:0] PH_RELEASE = 3'd1;
  localparam logic [PHASE_W-1:0] PH_WAIT    = 3'd2;
  localparam logic [PHASE_W-1:0] PH_SAMPLE  = 3'd3;
  localparam logic [PHASE_W-1:0] PH_LAST    = 3'd4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_BITS,
    ST_ACK,
    ST_STOP
  } engState_t;

  typedef struct packed {
    logic tickEn;
    logic loadTx;
    logic sampleData;
    logic sampleAck;
    logic clrStatus;
    logic setArb;
  } engStrobe_t;

endpackage

// File: rtl/i2c_eng_sync.sv
module i2c_eng_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : gStage
      if (g == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[0] <= RESET_VAL;
          else       chain[0] <= din;
        end
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[g] <= RESET_VAL;
          else       chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/i2c_eng_datapath.sv
module i2c_eng_datapath
  import i2c_eng_pkg::*;
#(
  parameter int PRESCALE_W  = 16,
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [PRESCALE_W-1:0] prescale,
  input  engStrobe_t            stb,
  input  logic [BYTE_W-1:0]     txByte,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  output logic                  tick,
  output logic                  sclS,
  output logic                  sdaS,
  output logic                  txMsb,
  output logic [BYTE_W-1:0]     rxByte,
  output logic                  rxNack,
  output logic                  arbLost,
  output logic                  busBusy
);
  // tick generator
  logic [PRESCALE_W-1:0] preCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           preCnt <= '0;
    else if (!stb.tickEn || preCnt == '0) preCnt <= prescale;
    else                                 preCnt <= preCnt - 1'b1;
  end

  assign tick = stb.tickEn && (preCnt == '0);

  // line synchronisers
  i2c_eng_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) uSclSync (
    .clk(clk), .rstN(rstN), .din(sclIn), .dout(sclS)
  );
  i2c_eng_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) uSdaSync (
    .clk(clk), .rstN(rstN), .din(sdaIn), .dout(sdaS)
  );

  // start / stop detection on the synchronised lines
  logic sclPrev, sdaPrev, startSeen, stopSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign startSeen = sclS && sclPrev && sdaPrev && !sdaS;
  assign stopSeen  = sclS && sclPrev && !sdaPrev && sdaS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          busBusy <= 1'b0;
    else if (startSeen) busBusy <= 1'b1;
    else if (stopSeen)  busBusy <= 1'b0;
  end

  // shift registers
  logic [BYTE_W-1:0] txShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               txShift <= '0;
    else if (stb.loadTx)     txShift <= txByte;
    else if (stb.sampleData) txShift <= {txShift[BYTE_W-2:0], 1'b0};
  end

  assign txMsb = txShift[BYTE_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               rxByte <= '0;
    else if (stb.sampleData) rxByte <= {rxByte[BYTE_W-2:0], sdaS};
  end

  // status flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxNack  <= 1'b0;
      arbLost <= 1'b0;
    end else begin
      if (stb.clrStatus)      rxNack <= 1'b0;
      else if (stb.sampleAck) rxNack <= sdaS;
      if (stb.clrStatus)      arbLost <= 1'b0;
      else if (stb.setArb)    arbLost <= 1'b1;
    end
  end
endmodule

// File: rtl/i2c_eng_ctrl.sv
module i2c_eng_ctrl
  import i2c_eng_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic       cmdStart,
  input  logic       cmdStop,
  input  logic       cmdRead,
  input  logic       cmdNack,
  input  logic       tick,
  input  logic       sclS,
  input  logic       sdaS,
  input  logic       txMsb,
  output logic       cmdReady,
  output logic       tip,
  output logic       done,
  output logic       sclOe,
  output logic       sdaOe,
  output engStrobe_t stb
);
  localparam int CNT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  engState_t          state;
  logic [PHASE_W-1:0] phase;
  logic [CNT_W-1:0]   bitCnt;
  logic               opStop, opRead, opNack;
  logic               accept, adv;

  assign cmdReady = (state == ST_IDLE);
  assign tip      = (state != ST_IDLE);
  assign accept   = cmdValid && cmdReady;
  // the high phase only moves on once SCL is really seen high
  assign adv      = tick && !(phase == PH_WAIT && !sclS);

  always_comb begin
    stb            = '0;
    stb.tickEn     = tip;
    stb.loadTx     = accept;
    stb.clrStatus  = accept;
    stb.sampleData = adv && (state == ST_BITS) && (phase == PH_SAMPLE);
    stb.sampleAck  = adv && (state == ST_ACK) && (phase == PH_SAMPLE);
    stb.setArb     = stb.sampleData && !opRead && txMsb && !sdaS;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      phase  <= PH_DRIVE;
      bitCnt <= '0;
      opStop <= 1'b0;
      opRead <= 1'b0;
      opNack <= 1'b0;
      sclOe  <= 1'b0;
      sdaOe  <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            opStop <= cmdStop;
            opRead <= cmdRead;
            opNack <= cmdNack;
            phase  <= PH_DRIVE;
            bitCnt <= '0;
            state  <= cmdStart ? ST_START : ST_BITS;
          end
        end

        ST_START: begin
          if (adv) begin
            phase <= phase + 1'b1;
            unique case (phase)
              PH_DRIVE:   sdaOe <= 1'b0;
              PH_RELEASE: sclOe <= 1'b0;
              PH_SAMPLE:  sdaOe <= 1'b1;
              PH_LAST: begin
                sclOe <= 1'b1;
                phase <= PH_DRIVE;
                state <= ST_BITS;
              end
              default: ;
            endcase
          end
        end

        ST_BITS: begin
          if (adv) begin
            phase <= phase + 1'b1;
            unique case (phase)
              PH_DRIVE:   sdaOe <= opRead ? 1'b0 : !txMsb;
              PH_RELEASE: sclOe <= 1'b0;
              PH_SAMPLE: begin
                if (stb.setArb) begin
                  sclOe <= 1'b0;
                  sdaOe <= 1'b0;
                  phase <= PH_DRIVE;
                  state <= ST_IDLE;
                  done  <= 1'b1;
                end
              end
              PH_LAST: begin
                sclOe <= 1'b1;
                phase <= PH_DRIVE;
                if (bitCnt == LAST_BIT) state <= ST_ACK;
                else                    bitCnt <= bitCnt + 1'b1;
              end
              default: ;
            endcase
          end
        end

        ST_ACK: begin
          if (adv) begin
            phase <= phase + 1'b1;
            unique case (phase)
              PH_DRIVE:   sdaOe <= opRead ? !opNack : 1'b0;
              PH_RELEASE: sclOe <= 1'b0;
              PH_LAST: begin
                sclOe <= 1'b1;
                phase <= PH_DRIVE;
                if (opStop) begin
                  state <= ST_STOP;
                end else begin
                  state <= ST_IDLE;
                  done  <= 1'b1;
                end
              end
              default: ;
            endcase
          end
        end

        ST_STOP: begin
          if (adv) begin
            phase <= phase + 1'b1;
            unique case (phase)
              PH_DRIVE:   sdaOe <= 1'b1;
              PH_RELEASE: sclOe <= 1'b0;
              PH_SAMPLE:  sdaOe <= 1'b0;
              PH_LAST: begin
                phase <= PH_DRIVE;
                state <= ST_IDLE;
                done  <= 1'b1;
              end
              default: ;
            endcase
          end
        end

        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import i2c_eng_pkg::*;
#(
  parameter int PRESCALE_W  = 16,
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [PRESCALE_W-1:0] prescale,
  input  logic                  cmdValid,
  output logic                  cmdReady,
  input  logic                  cmdStart,
  input  logic                  cmdStop,
  input  logic                  cmdRead,
  input  logic                  cmdNack,
  input  logic [BYTE_W-1:0]     txByte,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  output logic                  sclOe,
  output logic                  sdaOe,
  output logic [BYTE_W-1:0]     rxByte,
  output logic                  rxNack,
  output logic                  arbLost,
  output logic                  busBusy,
  output logic                  tip,
  output logic                  done
);
  engStrobe_t stb;
  logic       tick, sclS, sdaS, txMsb;

  i2c_eng_ctrl #(.BYTE_W(BYTE_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdStart (cmdStart),
    .cmdStop  (cmdStop),
    .cmdRead  (cmdRead),
    .cmdNack  (cmdNack),
    .tick     (tick),
    .sclS     (sclS),
    .sdaS     (sdaS),
    .txMsb    (txMsb),
    .cmdReady (cmdReady),
    .tip      (tip),
    .done     (done),
    .sclOe    (sclOe),
    .sdaOe    (sdaOe),
    .stb      (stb)
  );

  i2c_eng_datapath #(
    .PRESCALE_W  (PRESCALE_W),
    .BYTE_W      (BYTE_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .prescale (prescale),
    .stb      (stb),
    .txByte   (txByte),
    .sclIn    (sclIn),
    .sdaIn    (sdaIn),
    .tick     (tick),
    .sclS     (sclS),
    .sdaS     (sdaS),
    .txMsb    (txMsb),
    .rxByte   (rxByte),
    .rxNack   (rxNack),
    .arbLost  (arbLost),
    .busBusy  (busBusy)
  );
endmodule

// File: rtl/i2c_byte_engine_chk.sv
module i2c_byte_engine_chk (
  input logic clk,
  input logic rstN,
  input logic cmdValid,
  input logic cmdReady,
  input logic tip,
  input logic done,
  input logic sclOe,
  input logic sdaOe,
  input logic arbLost
);
  // R1: tip only rises on an accepted handshake
  a_r1_accept: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tip) |-> $past(cmdValid && cmdReady));

  // R1: done marks the edge where tip falls
  a_r1_done_edge: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!tip && $past(tip)));

  // R1: done lasts a single cycle
  a_r1_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R7: after an arbitration loss the engine drives neither line
  a_r7_arb_release: assert property (@(posedge clk) disable iff (!rstN)
    (arbLost && !tip) |-> (!sclOe && !sdaOe));

  // R10: line drives hold still while idle
  a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!tip && $past(!tip)) |-> ($stable(sclOe) && $stable(sdaOe)));
endmodule

bind i2c_byte_engine i2c_byte_engine_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cmdValid (cmdValid),
  .cmdReady (cmdReady),
  .tip      (tip),
  .done     (done),
  .sclOe    (sclOe),
  .sdaOe    (sdaOe),
  .arbLost  (arbLost)
);

// File: tb/i2c_byte_engine_bench.sv
module i2c_byte_engine_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    string      req;
    int         cycles;
    bit         chkRx;
    logic [7:0] rx;
    bit         chkNack;
    logic       nack;
    logic       arb;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] prescale = 16'd3;
  logic        cmdValid = 1'b0, cmdStart = 1'b0, cmdStop = 1'b0;
  logic        cmdRead = 1'b0, cmdNack = 1'b0;
  logic [7:0]  txByte = 8'h00;
  logic        cmdReady, sclOe, sdaOe, rxNack, arbLost, busBusy, tip, done;
  logic [7:0]  rxByte;

  // slave model
  logic       slvArmed = 1'b0, slvStart = 1'b0, slvRead = 1'b0, slvAck = 1'b0;
  logic [7:0] slvData = 8'h00, slvRec = 8'h00;
  logic       slvMAck = 1'b0;
  logic       slvSdaOe = 1'b0, slvSclHold = 1'b0;
  int         slvFall = 0, slvStretchIdx = -1;

  wire sclLine = !(sclOe || slvSclHold);
  wire sdaLine = !(sdaOe || slvSdaOe);

  int nTests = 0, nFail = 0, busDrops = 0, cycCnt = 0;
  time lastFall = 0, sclPeriod = 0;
  bit finished = 1'b0;
  expItem_t expQ[$];

  i2c_byte_engine u_i2c_byte_engine (
    .clk(clk), .rstN(rstN), .prescale(prescale),
    .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdStart(cmdStart), .cmdStop(cmdStop), .cmdRead(cmdRead), .cmdNack(cmdNack),
    .txByte(txByte), .sclIn(sclLine), .sdaIn(sdaLine),
    .sclOe(sclOe), .sdaOe(sdaOe), .rxByte(rxByte), .rxNack(rxNack),
    .arbLost(arbLost), .busBusy(busBusy), .tip(tip), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int slvIdx();
    return slvStart ? slvFall - 1 : slvFall;
  endfunction

  function automatic logic slvDrive(input int i);
    if (i >= 0 && i < 8) return slvRead && !slvData[7-i];
    if (i == 8)          return !slvRead && slvAck;
    return 1'b0;
  endfunction

  always @(negedge sclLine) begin
    if (slvArmed) begin
      slvFall = slvFall + 1;
      #2 slvSdaOe = slvDrive(slvIdx());
      if (slvIdx() == slvStretchIdx) begin
        slvSclHold = 1'b1;
        @(negedge sclOe);
        repeat (9) @(negedge clk);
        slvSclHold = 1'b0;
      end
    end
  end

  always @(posedge sclLine) begin
    if (slvArmed) begin
      if (slvIdx() >= 0 && slvIdx() < 8) slvRec = {slvRec[6:0], sdaLine};
      else if (slvIdx() == 8)            slvMAck = sdaLine;
    end
  end

  always @(negedge sclLine) begin
    if (slvArmed) begin
      sclPeriod = $time - lastFall;
      lastFall  = $time;
    end
  end

  always @(negedge busBusy) if (rstN) busDrops++;

  // monitor: pops the scoreboard on every done pulse
  always @(negedge clk) begin
    if (tip) cycCnt++;
    if (done) begin
      if (expQ.size() == 0) begin
        check("R1 unexpected done", 32'd1, 32'd0);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        check({e.req, " duration"}, cycCnt, e.cycles);
        if (e.chkRx)   check("R4 rxByte", {24'd0, rxByte}, {24'd0, e.rx});
        if (e.chkNack) check("R3 rxNack", {31'd0, rxNack}, {31'd0, e.nack});
        check("R7 arbLost", {31'd0, arbLost}, {31'd0, e.arb});
      end
      cycCnt = 0;
    end
  end

  task automatic armSlave(input bit st, input bit rd, input logic [7:0] data,
                          input bit ack, input int stretchIdx);
    slvStart = st; slvRead = rd; slvData = data; slvAck = ack;
    slvStretchIdx = stretchIdx;
    slvFall = 0; slvRec = 8'h00; slvMAck = 1'b0;
    slvArmed = 1'b1;
    slvSdaOe = slvDrive(slvIdx());
  endtask

  task automatic runCmd(input bit st, input bit sp, input bit rd, input bit nk,
                        input logic [7:0] tx, input expItem_t e);
    expQ.push_back(e);
    @(negedge clk);
    while (!cmdReady) @(negedge clk);
    cmdValid = 1'b1; cmdStart = st; cmdStop = sp; cmdRead = rd; cmdNack = nk; txByte = tx;
    @(negedge clk);
    cmdValid = 1'b0;
    check("R1 tip after accept", {31'd0, tip}, 32'd1);
    check("R1 ready low while busy", {31'd0, cmdReady}, 32'd0);
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nTests++; nFail++;
      $display("FAIL watchdog expired: actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    expItem_t e;
    int drops;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 sclOe", {31'd0, sclOe}, 32'd0);
    check("R11 sdaOe", {31'd0, sdaOe}, 32'd0);
    check("R11 tip", {31'd0, tip}, 32'd0);
    check("R11 done", {31'd0, done}, 32'd0);
    check("R11 busBusy", {31'd0, busBusy}, 32'd0);
    check("R11 cmdReady", {31'd0, cmdReady}, 32'd1);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // start + write, no stop, slave ACK
    armSlave(1, 0, 8'h00, 1, -1);
    e = '{req:"R2 start+byte", cycles:50*4, chkRx:0, rx:8'h00, chkNack:1, nack:1'b0, arb:1'b0};
    runCmd(1, 0, 0, 0, 8'h3C, e);
    check("R3 slave received", {24'd0, slvRec}, 32'h3C);
    check("R2 SCL period ns", sclPeriod, 5 * 4 * CLK_PERIOD);
    check("R5 busy after start", {31'd0, busBusy}, 32'd1);
    repeat (20) @(negedge clk);
    check("R10 SCL held low", {31'd0, sclOe}, 32'd1);

    // repeated start + write, slave NACK
    drops = busDrops;
    armSlave(1, 0, 8'h00, 0, -1);
    e = '{req:"R2 restart+byte", cycles:50*4, chkRx:0, rx:8'h00, chkNack:1, nack:1'b1, arb:1'b0};
    runCmd(1, 0, 0, 0, 8'hA1, e);
    check("R3 slave received", {24'd0, slvRec}, 32'hA1);
    check("R5 no stop during repeated start", busDrops, drops);

    // read with ACK, no start, no stop
    armSlave(0, 1, 8'hA5, 0, -1);
    e = '{req:"R2 byte only", cycles:45*4, chkRx:1, rx:8'hA5, chkNack:0, nack:1'b0, arb:1'b0};
    runCmd(0, 0, 1, 0, 8'h00, e);
    check("R4 master ACK level", {31'd0, slvMAck}, 32'd0);

    // read with NACK and stop
    armSlave(0, 1, 8'h5A, 0, -1);
    e = '{req:"R2 byte+stop", cycles:50*4, chkRx:1, rx:8'h5A, chkNack:0, nack:1'b0, arb:1'b0};
    runCmd(0, 1, 1, 1, 8'h00, e);
    check("R4 master NACK level", {31'd0, slvMAck}, 32'd1);
    check("R6 sclOe after stop", {31'd0, sclOe}, 32'd0);
    check("R6 sdaOe after stop", {31'd0, sdaOe}, 32'd0);
    check("R8 busy cleared by stop", {31'd0, busBusy}, 32'd0);
    slvArmed = 1'b0;

    // other prescale
    prescale = 16'd6;
    armSlave(1, 0, 8'h00, 1, -1);
    e = '{req:"R2 prescale 6", cycles:55*7, chkRx:0, rx:8'h00, chkNack:1, nack:1'b0, arb:1'b0};
    runCmd(1, 1, 0, 0, 8'h81, e);
    check("R3 slave received", {24'd0, slvRec}, 32'h81);
    check("R8 busy after full frame", {31'd0, busBusy}, 32'd0);
    slvArmed = 1'b0;
    prescale = 16'd3;

    // clock stretching on bit 3
    armSlave(1, 0, 8'h00, 1, 3);
    e = '{req:"R9 stretched", cycles:55*4 + 2*4, chkRx:0, rx:8'h00, chkNack:1, nack:1'b0, arb:1'b0};
    runCmd(1, 1, 0, 0, 8'h55, e);
    check("R9 slave received", {24'd0, slvRec}, 32'h55);
    slvArmed = 1'b0;

    // arbitration loss at bit 2
    armSlave(1, 1, 8'hDF, 0, -1);
    e = '{req:"R7 arbitration", cycles:19*4, chkRx:0, rx:8'h00, chkNack:0, nack:1'b0, arb:1'b1};
    runCmd(1, 0, 0, 0, 8'hFF, e);
    check("R7 sclOe released", {31'd0, sclOe}, 32'd0);
    check("R7 sdaOe released", {31'd0, sdaOe}, 32'd0);
    check("R8 busy held by other master", {31'd0, busBusy}, 32'd1);
    slvArmed = 1'b0;
    slvSdaOe = 1'b0;
    repeat (6) @(negedge clk);
    check("R8 foreign stop clears busy", {31'd0, busBusy}, 32'd0);

    // next command clears arbLost
    armSlave(1, 0, 8'h00, 1, -1);
    e = '{req:"R7 recovery", cycles:55*4, chkRx:0, rx:8'h00, chkNack:1, nack:1'b0, arb:1'b0};
    runCmd(1, 1, 0, 0, 8'h00, e);
    check("R3 slave received", {24'd0, slvRec}, 32'h00);
    slvArmed = 1'b0;

    repeat (5) @(negedge clk);
    check("R1 scoreboard drained", expQ.size(), 0);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule